// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Generator

This block drives the four switches of a full-bridge inverter that uses phase-shift control. It runs from a fast system clock and divides it into a fixed switching period; by default one period is 500 clock cycles. The first leg runs as a square wave with exactly half duty. The second leg is a copy of the first leg, delayed by a number of cycles. That delay is the width of the pulse you get by comparing a control word against a sawtooth that restarts when the first leg turns on.

Each leg's high-side and low-side commands are complementary. A programmable number of dead cycles is added after every change of leg state, and during those cycles both commands of the leg are low. The block also outputs a three-level sign of the bridge voltage, taken from the two leg states before dead time. It also outputs the sawtooth phase for use by downstream timing logic. A control loop upstream writes the control word at any time. The block takes a new value only at a period boundary.

Top module: `psfb_gate_gen`

## Requirements
- R1: `saw_phase` starts at 0 and rises by one each enabled cycle. After PERIOD-1 (499) it wraps to 0, and it reads 0 in every cycle that follows a cycle with `en` low.
- R2: The leg-one level is high while the sawtooth is below PERIOD/2 (250). The leg-one gate commands follow that level one clock later.
- R3: With latched shift s, the leg-two level is high while the sawtooth lies in [s, s+250). The leg-two gate commands follow that level one clock later.
- R4: A control word above PERIOD/2 (250) is clamped to 250, which is a 180-degree shift.
- R5: The control word is captured at the edge where `saw_phase` is 499, and on every edge while `en` is low. At any other time a change of `ctrl_word` has no effect on the gates.
- R6: After each change of a leg's level, both gate commands of that leg stay low for `dead_cyc` cycles. After that, exactly one of them is high.
- R7: With `dead_cyc` = 0, each leg's low-side command is the exact complement of its high-side command, with no gap.
- R8: `bridge_sign` is 2'b01 (positive) when leg one is high and leg two is low. It is 2'b11 (negative) when leg one is low and leg two is high. It is 2'b00 otherwise and while `en` is low. It is based on the levels before dead time.
- R9: While `en` is low, all four gate commands are low. Reset gives a sawtooth of 0 and all gates low.
- R10: A control word of 0 keeps the two legs in phase, so `bridge_sign` stays 2'b00 in every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low forces gates off and clears the period counter |
| ctrl_word | input | 9 | Phase-shift command in clock cycles |
| dead_cyc | input | 5 | Dead time in clock cycles (0 to 31) |
| leg1_hi | output | 1 | Leg-one high-side gate command |
| leg1_lo | output | 1 | Leg-one low-side gate command |
| leg2_hi | output | 1 | Leg-two high-side gate command |
| leg2_lo | output | 1 | Leg-two low-side gate command |
| bridge_sign | output | 2 | Bridge voltage sign: 01 positive, 11 negative, 00 zero |
| saw_phase | output | 9 | Current sawtooth phase (period counter) |

## Verification
Two events can fall in the same cycle: the capture of a new shift at the period wrap, and a leg-two edge that the new shift moves to cycle 0. For example, a shift of 250 followed by a shift of 3 gives leg two a low stretch of only three cycles, which is shorter than the dead time. The bench provokes this by changing `ctrl_word` in mid-period and at the wrap, and with large and zero dead times. A cycle-by-cycle behavioural model checks that the dead-time window restarts and holds both gates low throughout, and that the sign still follows the levels before dead time.

// File: rtl/psfb_pkg.sv
// Shared types for the phase-shift gate generator.
// Assumes: the sign code is decoded by logic outside this block.
package psfb_pkg;
    typedef enum logic [1:0] {
        SIGN_ZERO = 2'b00,
        SIGN_POS  = 2'b01,
        SIGN_NEG  = 2'b11
    } bridge_sign_e;
endpackage

// File: rtl/psfb_timebase.sv
// Period counter, shift latch and leg levels for the phase-shift bridge.
// Assumes: PERIOD is even, and the control word is sampled only at period
// boundaries or while disabled.
module psfb_timebase
    import psfb_pkg::*;
#(
    parameter int PERIOD = 500,
    parameter int CW_W   = 9,
    localparam int CNT_W = $clog2(PERIOD),
    localparam int HALF  = PERIOD / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CW_W-1:0]  ctrl_word,
    output logic [CNT_W-1:0] phase,
    output logic             lvl_a,
    output logic             lvl_b,
    output logic [1:0]       sign
);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W:0]   HALFW = (CNT_W+1)'(HALF);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] shift_q;
    logic [CNT_W-1:0] shift_clamped;
    logic [CNT_W:0]   cnt_ext;
    logic [CNT_W:0]   shift_ext;

    // Limit the command to a half period (180 degrees).
    assign shift_clamped = ((CW_W+1)'(ctrl_word) > (CW_W+1)'(HALF)) ? CNT_W'(HALF)
                                                                  : CNT_W'(ctrl_word);

    // Period counter: cleared while disabled, wraps at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)     cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    // Shift latch: updated only at the wrap or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                       shift_q <= '0;
        else if (!en || cnt_q == LAST)    shift_q <= shift_clamped;
    end

    assign cnt_ext   = {1'b0, cnt_q};
    assign shift_ext = {1'b0, shift_q};
    assign phase     = cnt_q;
    assign lvl_a     = (cnt_ext < HALFW);
    assign lvl_b     = (cnt_ext >= shift_ext) && (cnt_ext < shift_ext + HALFW);

    // Three-level sign from the raw leg levels.
    always_comb begin
        if (!en)                 sign = SIGN_ZERO;
        else if (lvl_a && !lvl_b) sign = SIGN_POS;
        else if (!lvl_a && lvl_b) sign = SIGN_NEG;
        else                     sign = SIGN_ZERO;
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en && cnt_q == LAST |=> cnt_q == '0);
    assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == '0);
    assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_q <= CNT_W'(HALF));
    assert_hold_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en && cnt_q != LAST |=> $stable(shift_q));
    assert_sign_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sign != 2'b10);
endmodule

// File: rtl/psfb_deadtime.sv
// Turns one leg level into complementary high/low gate commands with dead time.
// Assumes: dead time is shorter than half a period; a new level change
// during the dead window restarts it.
module psfb_deadtime #(
    parameter int DT_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            level,
    input  logic [DT_W-1:0] dead_cyc,
    output logic            gate_hi,
    output logic            gate_lo
);
    logic            lvl_q;
    logic [DT_W-1:0] dcnt_q;
    logic            settled;

    // Track the level and run the blanking counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            dcnt_q <= '0;
        end else begin
            lvl_q <= level;
            if (!en)                  dcnt_q <= '0;
            else if (level != lvl_q)  dcnt_q <= dead_cyc;
            else if (dcnt_q != '0)    dcnt_q <= dcnt_q - 1'b1;
        end
    end

    assign settled = (dcnt_q == '0);
    assign gate_hi = en &  lvl_q & settled;
    assign gate_lo = en & ~lvl_q & settled;

    assert_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en && (level != lvl_q) && dead_cyc != '0 |=> !gate_hi && !gate_lo);
    assert_zero_dt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en && dead_cyc == '0 && $past(dead_cyc) == '0 && $past(en) |-> gate_hi != gate_lo);
    assert_idle_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !gate_hi && !gate_lo);
endmodule

// File: rtl/psfb_gate_gen.sv
// Top of the phase-shift full-bridge gate generator: one timebase and a
// dead-time stage per leg.
// Assumes: synchronous active-low reset; inputs are synchronous to clk.
module psfb_gate_gen #(
    parameter int PERIOD = 500,
    parameter int CW_W   = 9,
    parameter int DT_W   = 5,
    localparam int CNT_W = $clog2(PERIOD),
    localparam int NLEG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CW_W-1:0]  ctrl_word,
    input  logic [DT_W-1:0]  dead_cyc,
    output logic             leg1_hi,
    output logic             leg1_lo,
    output logic             leg2_hi,
    output logic             leg2_lo,
    output logic [1:0]       bridge_sign,
    output logic [CNT_W-1:0] saw_phase
);
    logic [NLEG-1:0] lvl;
    logic [NLEG-1:0] hi;
    logic [NLEG-1:0] lo;

    psfb_timebase #(.PERIOD(PERIOD), .CW_W(CW_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ctrl_word (ctrl_word),
        .phase     (saw_phase),
        .lvl_a     (lvl[0]),
        .lvl_b     (lvl[1]),
        .sign      (bridge_sign)
    );

    // One dead-time stage per bridge leg.
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        psfb_deadtime #(.DT_W(DT_W)) u_dt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .level    (lvl[g]),
            .dead_cyc (dead_cyc),
            .gate_hi  (hi[g]),
            .gate_lo  (lo[g])
        );
    end

    assign leg1_hi = hi[0];
    assign leg1_lo = lo[0];
    assign leg2_hi = hi[1];
    assign leg2_lo = lo[1];
endmodule

// File: tb/psfb_gate_gen_test.sv
module psfb_gate_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [8:0] ctrl_word = '0;
    logic [4:0] dead_cyc = '0;
    logic       leg1_hi, leg1_lo, leg2_hi, leg2_lo;
    logic [1:0] bridge_sign;
    logic [8:0] saw_phase;

    int checks = 0;
    int errors = 0;
    int m_c = 0, m_s = 0;
    int m_lv[2] = '{0, 0};
    int m_d[2]  = '{0, 0};
    bit started = 0;
    bit done = 0;
    int nonzero_sign_in_phase = 0;

    always #5 clk = ~clk;

    psfb_gate_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en), .ctrl_word(ctrl_word),
        .dead_cyc(dead_cyc), .leg1_hi(leg1_hi), .leg1_lo(leg1_lo),
        .leg2_hi(leg2_hi), .leg2_lo(leg2_lo), .bridge_sign(bridge_sign),
        .saw_phase(saw_phase)
    );

    function automatic int raw1(int c);
        return (c < 250) ? 1 : 0;
    endfunction
    function automatic int raw2(int c, int s);
        return (c >= s && c < s + 250) ? 1 : 0;
    endfunction

    // Behavioural reference: advance one clock.
    always @(posedge clk) begin
        int r[2];
        int nc, ns;
        started = 1;
        if (!rst_n) begin
            m_c = 0; m_s = 0; m_lv = '{0, 0}; m_d = '{0, 0};
        end else begin
            r[0] = raw1(m_c);
            r[1] = raw2(m_c, m_s);
            for (int k = 0; k < 2; k++) begin
                if (!en)                m_d[k] = 0;
                else if (r[k] != m_lv[k]) m_d[k] = dead_cyc;
                else if (m_d[k] > 0)    m_d[k] = m_d[k] - 1;
                m_lv[k] = r[k];
            end
            nc = (!en || m_c == 499) ? 0 : m_c + 1;
            ns = (!en || m_c == 499) ? ((ctrl_word > 250) ? 250 : ctrl_word) : m_s;
            m_c = nc; m_s = ns;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        int e_hi[2], e_lo[2], e_sg, a, b;
        if (started && !done) begin
            for (int k = 0; k < 2; k++) begin
                e_hi[k] = (en && m_lv[k] == 1 && m_d[k] == 0) ? 1 : 0;
                e_lo[k] = (en && m_lv[k] == 0 && m_d[k] == 0) ? 1 : 0;
            end
            a = raw1(m_c); b = raw2(m_c, m_s);
            e_sg = !en ? 0 : (a == 1 && b == 0) ? 1 : (a == 0 && b == 1) ? 3 : 0;
            chk("R1", "saw_phase", saw_phase, m_c);
            chk("R2", "leg1_hi", leg1_hi, e_hi[0]);
            chk("R6", "leg1_lo", leg1_lo, e_lo[0]);
            chk("R3", "leg2_hi", leg2_hi, e_hi[1]);
            chk("R6", "leg2_lo", leg2_lo, e_lo[1]);
            chk("R8", "bridge_sign", bridge_sign, e_sg);
            if (!en) chk("R9", "idle gates", leg1_hi | leg1_lo | leg2_hi | leg2_lo, 0);
            if (en && dead_cyc == 0 && m_d[0] == 0 && m_d[1] == 0)
                chk("R7", "complement", (leg1_hi ^ leg1_lo) & (leg2_hi ^ leg2_lo), 1);
            if (en && m_s == 0 && bridge_sign != 2'b00) nonzero_sign_in_phase++;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_phase(int p);
        do begin @(posedge clk); #2; end while (saw_phase != p[8:0]);
    endtask

    initial begin
        wait_cyc(3);
        chk("R9", "reset saw", saw_phase, 0);
        chk("R9", "reset gates", leg1_hi | leg1_lo | leg2_hi | leg2_lo, 0);
        rst_n = 1'b1;
        // R2/R3/R6: 100-cycle shift, dead time 5.
        ctrl_word = 9'd100; dead_cyc = 5'd5;
        wait_cyc(4);
        en = 1'b1;
        wait_cyc(1100);
        // R5: mid-period change takes effect only at the wrap.
        wait_phase(120);
        ctrl_word = 9'd40;
        wait_cyc(1);
        chk("R5", "leg2 held mid-period", leg2_hi, 1);
        wait_cyc(1000);
        // R4: clamp to 180 degrees, then a short low pulse across the wrap.
        ctrl_word = 9'd400; dead_cyc = 5'd31;
        wait_cyc(1000);
        wait_phase(300);
        ctrl_word = 9'd3;
        wait_cyc(700);
        // R7: zero dead time.
        dead_cyc = 5'd0; ctrl_word = 9'd175;
        wait_cyc(1100);
        // R10: in phase.
        ctrl_word = 9'd0; dead_cyc = 5'd7;
        wait_cyc(1100);
        chk("R10", "sign in phase nonzero count", nonzero_sign_in_phase, 0);
        // R9: disable mid-period and resume.
        wait_phase(333);
        en = 1'b0; ctrl_word = 9'd250;
        wait_cyc(20);
        chk("R9", "idle saw", saw_phase, 0);
        en = 1'b1;
        wait_cyc(1100);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule